// File: doc/BRIEF.md
# Eight-Point Inverse DCT Engine

This block computes a one-dimensional eight-point inverse discrete cosine transform on one coefficient vector per clock cycle. Each vector is eight signed 16-bit coefficients, presented together with a valid strobe and a mode bit. The arithmetic is fixed and bit-exact. Every product uses a 14-bit fixed-point cosine constant and is rounded to nearest by adding 8192 and then shifting right arithmetically by 14. The even half and the odd half are computed separately and then merged by a final butterfly.

A decoder uses the engine twice for each block. The first pass runs in row mode and returns the raw butterfly results, truncated to 16 bits. The second pass runs in reconstruct mode: each result is scaled by (y+16)>>5, added to the matching 8-bit prediction pixel, and clamped to 0..255. The mode travels with its vector, so one stream can interleave row and reconstruct vectors. The transpose memory between the two passes sits outside this block.

Top module: `idct8_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `outValid` is low.
- R2: A vector accepted on a clock edge with `inValid` high produces its result with `outValid` high exactly three clock edges later. Vectors may arrive on consecutive cycles, and results leave in arrival order.
- R3: Each constant product is rounded as (p + 8192) >>> 14 with floor semantics for negative values. The constants are C4=16069, C8=15137, C12=13623, C16=11585, C20=9102, C24=6270 and C28=3196.
- R4: The even terms are e0=rnd((x0+x4)·C16), e1=rnd((x0−x4)·C16), e2=rnd(x2·C24−x6·C8) and e3=rnd(x2·C8+x6·C24). They merge into a0=e0+e3, a1=e1+e2, a2=e1−e2 and a3=e0−e3.
- R5: The odd terms are o4=rnd(x1·C28−x7·C4), o7=rnd(x1·C4+x7·C28), o5=rnd(x5·C12−x3·C20) and o6=rnd(x5·C20+x3·C12). From these, b4=o4+o5 and b7=o6+o7. The rotated terms b5=rnd((o7−o6−o4+o5)·C16) and b6=rnd((o4−o5−o6+o7)·C16) both use the unmodified o terms.
- R6: Coefficient xk enters on `inCoef[16k+15:16k]`. Result lanes are y0=a0+b7, y1=a1+b6, y2=a2+b5, y3=a3+b4, y4=a3−b4, y5=a2−b5, y6=a1−b6 and y7=a0−b7, with yk on `outData[16k+15:16k]`.
- R7: With `inMode`=0 (row mode), each output lane carries yk truncated to its low 16 bits.
- R8: With `inMode`=1 (reconstruct mode), lane k carries clamp((yk+16)>>>5 + pk, 0, 255) in bits [7:0] and zero in bits [15:8]. Here pk is the unsigned pixel on `inPred[8k+7:8k]`.
- R9: The mode is sampled with each vector and applies only to that vector, even when the two modes alternate on consecutive cycles.
- R10: A cycle with `inValid` low produces no result: `outValid` stays low three edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input vector strobe |
| inMode | input | 1 | 0 = row mode, 1 = reconstruct mode |
| inCoef | input | 128 | Eight signed 16-bit coefficients, lane k = xk |
| inPred | input | 64 | Eight unsigned prediction pixels, lane k = pk |
| outValid | output | 1 | Result strobe |
| outData | output | 128 | Eight 16-bit result lanes |

## Verification
The bench drives single-coefficient impulses of both signs into every lane. Any swapped constant, misplaced lane or missing minus sign in one of the butterflies then appears as a wrong value in a specific output lane. Vectors of ±1 and ±2 test the rounding: a design that truncates instead of adding 8192 first, or that shifts logically, returns 0 where −1 is expected. Reconstruct vectors with extreme DC values and prediction pixels near 0 and 255 test the clamp at both ends; a missing clamp lets the low byte wrap. Full-scale row vectors check that out-of-range sums wrap to 16 bits. A long stream that alternates the two modes and contains gaps would expose a mode bit or valid bit that drifts out of step with its data.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
  localparam int LANES = 8;
  localparam int HALF  = LANES / 2;
  localparam int FRAC  = 14;
  localparam int ROUND_OFS = 1 << (FRAC - 1);

  localparam int C4  = 16069;
  localparam int C8  = 15137;
  localparam int C12 = 13623;
  localparam int C16 = 11585;
  localparam int C20 = 9102;
  localparam int C24 = 6270;
  localparam int C28 = 3196;

  // strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic s1En;     // load product stage
    logic s2En;     // load merge stage
    logic s3En;     // load output stage
    logic reconS3;  // mode of the vector entering the output stage
  } idct_strb_t;
endpackage

// File: rtl/idct8_ctrl.sv
module idct8_ctrl
  import idct8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inMode,
  output idct_strb_t strb,
  output logic       outValid
);
  logic v1, v2, v3;
  logic m1, m2, m3;
  logic [1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      m1 <= 1'b0; m2 <= 1'b0; m3 <= 1'b0;
      age <= '0;
    end else begin
      v1 <= inValid; v2 <= v1; v3 <= v2;
      m1 <= inMode;  m2 <= m1; m3 <= m2;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  always_comb begin
    strb.s1En    = inValid;
    strb.s2En    = v1;
    strb.s3En    = v2;
    strb.reconS3 = m2;
  end

  assign outValid = v3;

  // a result appears exactly three edges after its vector (R2, R10)
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (outValid == $past(inValid, 3)));

  // the mode leaving the pipe is the one that came with the vector (R9)
  assert_mode_align_R9: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && v3) |-> (m3 == $past(inMode, 3)));

  // nothing leaves the pipe on the first edge after reset (R1)
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd0) |-> !outValid);
endmodule

// File: rtl/idct8_dp.sv
module idct8_dp
  import idct8_pkg::*;
#(
  parameter int COEF_W      = 16,
  parameter int PIX_W       = 8,
  parameter int ACC_W       = 36,
  parameter int RECON_SHIFT = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  idct_strb_t                strb,
  input  logic [LANES*COEF_W-1:0]   inCoef,
  input  logic [LANES*PIX_W-1:0]    inPred,
  output logic [LANES*COEF_W-1:0]   outData
);
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t K4   = acc_t'(C4);
  localparam acc_t K8   = acc_t'(C8);
  localparam acc_t K12  = acc_t'(C12);
  localparam acc_t K16  = acc_t'(C16);
  localparam acc_t K20  = acc_t'(C20);
  localparam acc_t K24  = acc_t'(C24);
  localparam acc_t K28  = acc_t'(C28);
  localparam acc_t RND  = acc_t'(ROUND_OFS);
  localparam acc_t SOFS = acc_t'(1 << (RECON_SHIFT - 1));
  localparam acc_t PMAX = acc_t'((1 << PIX_W) - 1);

  function automatic acc_t rnd(input acc_t v);
    return (v + RND) >>> FRAC;
  endfunction

  // ---------------- unpack ----------------
  acc_t x [LANES];
  for (genvar k = 0; k < LANES; k++) begin : g_unpack
    assign x[k] = acc_t'($signed(inCoef[k*COEF_W +: COEF_W]));
  end

  // ---------------- stage 1: rounded products ----------------
  acc_t eNext [HALF];
  acc_t oNext [HALF];  // index 0..3 holds o4..o7
  always_comb begin
    eNext[0] = rnd((x[0] + x[4]) * K16);
    eNext[1] = rnd((x[0] - x[4]) * K16);
    eNext[2] = rnd(x[2] * K24 - x[6] * K8);
    eNext[3] = rnd(x[2] * K8  + x[6] * K24);
    oNext[0] = rnd(x[1] * K28 - x[7] * K4);
    oNext[3] = rnd(x[1] * K4  + x[7] * K28);
    oNext[1] = rnd(x[5] * K12 - x[3] * K20);
    oNext[2] = rnd(x[5] * K20 + x[3] * K12);
  end

  acc_t eq [HALF];
  acc_t oq [HALF];
  logic [LANES*PIX_W-1:0] pred1, pred2;

  always_ff @(posedge clk) begin
    if (strb.s1En) begin
      eq    <= eNext;
      oq    <= oNext;
      pred1 <= inPred;
    end
  end

  // ---------------- stage 2: butterflies and middle rotation ----------------
  acc_t aNext [HALF];
  acc_t bNext [HALF];  // index k pairs with aNext[k]: b7, b6, b5, b4
  always_comb begin
    aNext[0] = eq[0] + eq[3];
    aNext[1] = eq[1] + eq[2];
    aNext[2] = eq[1] - eq[2];
    aNext[3] = eq[0] - eq[3];
    bNext[0] = oq[2] + oq[3];
    bNext[1] = rnd((oq[0] - oq[1] - oq[2] + oq[3]) * K16);
    bNext[2] = rnd((oq[3] - oq[2] - oq[0] + oq[1]) * K16);
    bNext[3] = oq[0] + oq[1];
  end

  acc_t aq [HALF];
  acc_t bq [HALF];
  always_ff @(posedge clk) begin
    if (strb.s2En) begin
      aq    <= aNext;
      bq    <= bNext;
      pred2 <= pred1;
    end
  end

  // ---------------- stage 3: final butterfly and pixel add ----------------
  acc_t ySum [LANES];
  for (genvar k = 0; k < HALF; k++) begin : g_bfly
    assign ySum[k]           = aq[k] + bq[k];
    assign ySum[LANES-1-k]   = aq[k] - bq[k];
  end

  logic [COEF_W-1:0] laneNext [LANES];
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    acc_t scaled;
    acc_t pixSum;
    logic [PIX_W-1:0] clamped;
    assign scaled  = (ySum[k] + SOFS) >>> RECON_SHIFT;
    assign pixSum  = scaled + acc_t'({1'b0, pred2[k*PIX_W +: PIX_W]});
    assign clamped = (pixSum < 0)    ? '0 :
                     (pixSum > PMAX) ? PMAX[PIX_W-1:0] :
                                       pixSum[PIX_W-1:0];
    assign laneNext[k] = strb.reconS3 ? COEF_W'(clamped) : ySum[k][COEF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.s3En) begin
      for (int k = 0; k < LANES; k++) outData[k*COEF_W +: COEF_W] <= laneNext[k];
    end
  end

  // upper byte of every lane, used to check reconstruct packing
  logic upperAny;
  always_comb begin
    upperAny = 1'b0;
    for (int k = 0; k < LANES; k++)
      upperAny = upperAny | (|outData[k*COEF_W+PIX_W +: COEF_W-PIX_W]);
  end

  // zero even inputs leave every even product zero (R4)
  assert_even_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s1En && x[0] == 0 && x[2] == 0 && x[4] == 0 && x[6] == 0)
    |=> (eq[0] == 0 && eq[1] == 0 && eq[2] == 0 && eq[3] == 0));

  // zero odd inputs leave every odd product zero (R5)
  assert_odd_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s1En && x[1] == 0 && x[3] == 0 && x[5] == 0 && x[7] == 0)
    |=> (oq[0] == 0 && oq[1] == 0 && oq[2] == 0 && oq[3] == 0));

  // a reconstruct result has zero in the high byte of every lane (R8)
  assert_recon_pack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s3En && strb.reconS3) |=> !upperAny);

  // a zero product stage gives a zero merge stage (R5)
  assert_merge_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2En && oq[0] == 0 && oq[1] == 0 && oq[2] == 0 && oq[3] == 0)
    |=> (bq[0] == 0 && bq[1] == 0 && bq[2] == 0 && bq[3] == 0));
endmodule

// File: rtl/idct8_engine.sv
module idct8_engine
  import idct8_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    inMode,
  input  logic [8*COEF_W-1:0]     inCoef,
  input  logic [8*PIX_W-1:0]      inPred,
  output logic                    outValid,
  output logic [8*COEF_W-1:0]     outData
);
  idct_strb_t strb;

  idct8_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (inMode),
    .strb     (strb),
    .outValid (outValid)
  );

  idct8_dp #(
    .COEF_W (COEF_W),
    .PIX_W  (PIX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inCoef  (inCoef),
    .inPred  (inPred),
    .outData (outData)
  );
endmodule

// File: tb/idct8_engine_tb_top.sv
`timescale 1ns/1ps
module idct8_engine_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inMode = 1'b0;
  logic [127:0] inCoef = '0;
  logic [63:0]  inPred = '0;
  logic outValid;
  logic [127:0] outData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [127:0] expQ[$];
  int           cycQ[$];
  string        tagQ[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  idct8_engine dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inCoef(inCoef), .inPred(inPred), .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint rnd(input longint v);
    return (v + 8192) >>> 14;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] c, input logic [63:0] p, input bit recon);
    longint x [8];
    longint e0, e1, e2, e3, a0, a1, a2, a3, o4, o5, o6, o7, b4, b5, b6, b7, t;
    longint y [8];
    logic [127:0] r;
    for (int k = 0; k < 8; k++) x[k] = longint'($signed(c[k*16 +: 16]));
    e0 = rnd((x[0] + x[4]) * 11585);
    e1 = rnd((x[0] - x[4]) * 11585);
    e2 = rnd(x[2] * 6270 - x[6] * 15137);
    e3 = rnd(x[2] * 15137 + x[6] * 6270);
    a0 = e0 + e3; a1 = e1 + e2; a2 = e1 - e2; a3 = e0 - e3;
    o4 = rnd(x[1] * 3196 - x[7] * 16069);
    o7 = rnd(x[1] * 16069 + x[7] * 3196);
    o5 = rnd(x[5] * 13623 - x[3] * 9102);
    o6 = rnd(x[5] * 9102 + x[3] * 13623);
    b5 = rnd((o7 - o6 - o4 + o5) * 11585);
    b6 = rnd((o4 - o5 - o6 + o7) * 11585);
    b4 = o4 + o5; b7 = o6 + o7;
    y[0] = a0 + b7; y[1] = a1 + b6; y[2] = a2 + b5; y[3] = a3 + b4;
    y[4] = a3 - b4; y[5] = a2 - b5; y[6] = a1 - b6; y[7] = a0 - b7;
    for (int k = 0; k < 8; k++) begin
      if (recon) begin
        t = ((y[k] + 16) >>> 5) + longint'(p[k*8 +: 8]);
        if (t < 0) t = 0;
        if (t > 255) t = 255;
        r[k*16 +: 16] = {8'h00, t[7:0]};
      end else begin
        r[k*16 +: 16] = y[k][15:0];
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] packc(input int v [8]);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) r[k*16 +: 16] = v[k][15:0];
    return r;
  endfunction

  // scoreboard: each accepted vector expects its result three edges later (R2, R6)
  always @(negedge clk) begin
    if (rstN && !finished && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected result", outData, '0);
      end else begin
        logic [127:0] e;
        int ec;
        string tg;
        e = expQ.pop_front(); ec = cycQ.pop_front(); tg = tagQ.pop_front();
        check(outData === e, tg, outData, e);
        check(cyc == ec, "R2 latency", 128'(cyc), 128'(ec));
      end
    end
  end

  task automatic send(input logic [127:0] c, input logic [63:0] p, input bit recon, input string tag);
    @(negedge clk);
    inValid = 1'b1; inCoef = c; inPred = p; inMode = recon;
    expQ.push_back(model(c, p, recon));
    cycQ.push_back(cyc + 3);
    tagQ.push_back(tag);
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    inValid = 1'b0; inCoef = '0; inMode = 1'b0;
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, tag, 128'(expQ.size()), '0);
    check(outValid == 1'b0, "R10 idle", 128'(outValid), '0);
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 in reset", 128'(outValid), '0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 after reset", 128'(outValid), '0);
  endtask

  // impulses in every lane, both signs, row mode: R4 R5 R6
  task automatic test_impulses();
    for (int k = 0; k < 8; k++) begin
      int v [8];
      foreach (v[j]) v[j] = 0;
      v[k] = 100;
      send(packc(v), '0, 1'b0, (k % 2 == 0) ? "R4 R6 even impulse" : "R5 R6 odd impulse");
      v[k] = -77;
      send(packc(v), '0, 1'b0, (k % 2 == 0) ? "R4 R6 even impulse neg" : "R5 R6 odd impulse neg");
    end
    drain("R6 impulse drain");
  endtask

  // small magnitudes where round-to-nearest matters: R3
  task automatic test_rounding();
    int vals [4] = '{1, -1, 2, -2};
    foreach (vals[i]) begin
      int v [8];
      foreach (v[j]) v[j] = 0;
      v[0] = vals[i];
      send(packc(v), '0, 1'b0, "R3 rounding dc");
      v[0] = 0; v[2] = vals[i]; v[5] = vals[i];
      send(packc(v), '0, 1'b0, "R3 rounding mixed");
    end
    drain("R3 drain");
  endtask

  // dense patterns through the rotation: R5
  task automatic test_patterns();
    send(packc('{0, 300, 0, -200, 0, 150, 0, 400}), '0, 1'b0, "R5 odd only");
    send(packc('{500, 0, -250, 0, 125, 0, 60, 0}), '0, 1'b0, "R4 even only");
    send(packc('{10, 20, 30, 40, 50, 60, 70, 80}), '0, 1'b0, "R4 R5 ramp");
    send(packc('{-1000, 900, -800, 700, -600, 500, -400, 300}), '0, 1'b0, "R4 R5 alternating");
    drain("R5 drain");
  endtask

  // full-scale row vectors that leave 16 bits: R7
  task automatic test_row_wrap();
    send(packc('{32767, 32767, 32767, -32768, 32767, 32767, -32768, 32767}), '0, 1'b0, "R7 wrap a");
    send(packc('{-32768, -32768, -32768, 32767, -32768, -32768, 32767, -32768}), '0, 1'b0, "R7 wrap b");
    drain("R7 drain");
  endtask

  // clamp at both ends and mid-range add: R8
  task automatic test_recon();
    send(packc('{32767, 0, 0, 0, 0, 0, 0, 0}), {8{8'd250}}, 1'b1, "R8 clamp high");
    send(packc('{-32768, 0, 0, 0, 0, 0, 0, 0}), {8{8'd5}}, 1'b1, "R8 clamp low");
    send(packc('{400, -300, 200, 100, -50, 25, 0, -10}), 64'h10_40_80_C0_F0_08_7F_01, 1'b1, "R8 midrange");
    send(packc('{-20, 0, 0, 0, 0, 0, 0, 0}), {8{8'd0}}, 1'b1, "R8 negative rounding");
    drain("R8 drain");
  endtask

  // back-to-back stream, alternating modes and gaps: R2 R9 R10
  task automatic test_stream();
    for (int n = 0; n < 40; n++) begin
      int v [8];
      foreach (v[j]) v[j] = int'($urandom_range(0, 4000)) - 2000;
      send(packc(v), {$urandom, $urandom}, n[0], "R9 mixed stream");
      if (n % 7 == 6) begin
        @(negedge clk);
        inValid = 1'b0;
      end
    end
    drain("R2 stream drain");
  endtask

  initial begin
    test_reset();
    test_impulses();
    test_rounding();
    test_patterns();
    test_row_wrap();
    test_recon();
    test_stream();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule